// File: doc/BRIEF.md
# Credit Tracker with Stall Watchdog

This block sits beside the output side of a virtual-channel router. For every pair of output port and output virtual channel it keeps a count of the free buffer slots in the next router. Sending a flit spends one slot. A returned credit gives one back. Each counter drives a credit-available bit, and the upstream switch logic uses that bit to decide whether a flit may leave on that channel.

Each counter has a stall timer beside it. A send puts the timer into its armed state with a value of zero. A credit returned on the same channel puts it back to idle. A free-running interval generator produces a tick every `CHECK_INTERVAL` cycles, and each tick advances every armed timer by one. When a timer goes past `STALL_LIMIT`, the block raises a sticky deadlock flag and latches the port and channel that caused it. A separate sticky error flag records any credit that arrives while its counter is already at the configured depth.

Top module: `credit_watchdog`

## Requirements
- R1: After reset every counter holds `CREDITS`, so every `credit_avail` bit is 1, and both `deadlock` and `overflow_err` are 0.
- R2: A send that finds credit lowers that channel's count by one. A returned credit raises it by one. Bit `port*NUM_VCS+vc` of `credit_avail` is 1 exactly when that count is above zero.
- R3: After `CREDITS` sends on one channel with no credit returned, that channel's `credit_avail` bit is 0.
- R4: A send on a channel whose count is zero is ignored. The count stays at zero, so one later credit brings it to exactly one.
- R5: A send and a credit return on the same channel in the same cycle leave that count unchanged.
- R6: A credit return on a channel already at `CREDITS` leaves the count at `CREDITS` and sets `overflow_err`. The flag stays set until reset.
- R7: A credit return puts the channel's stall timer back to idle. An idle timer never advances and never raises `deadlock`.
- R8: An armed timer advances once per `CHECK_INTERVAL` cycles. `deadlock` rises once the timer exceeds `STALL_LIMIT`. Counting from the clock edge that takes the send, this happens no earlier than `STALL_LIMIT*CHECK_INTERVAL+2` edges and no later than `(STALL_LIMIT+1)*CHECK_INTERVAL+1` edges.
- R9: `dl_port` and `dl_vc` give the channel whose timer expired first. If several expire in the same cycle, the lowest flat index `port*NUM_VCS+vc` is reported.
- R10: Once `deadlock` is set, it stays at 1 and `dl_port`/`dl_vc` keep their values until reset, even after the stalled channels receive credits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| send_valid | input | 1 | A flit leaves this cycle |
| send_port | input | PW | Output port of the sent flit |
| send_vc | input | VW | Output virtual channel of the sent flit |
| credit_valid | input | 1 | A credit returns this cycle |
| credit_port | input | PW | Output port the credit belongs to |
| credit_vc | input | VW | Virtual channel the credit belongs to |
| credit_avail | output | NUM_PORTS*NUM_VCS | Per-channel credit-available bits, index port*NUM_VCS+vc |
| deadlock | output | 1 | Sticky stall-detected flag |
| dl_port | output | PW | Port of the reported stalled channel |
| dl_vc | output | VW | Virtual channel of the reported stalled channel |
| overflow_err | output | 1 | Sticky credit-overflow flag |

## Verification
The assertions check the following on every cycle: the reset state, that a credit with no competing send always makes its channel available, that a send on an empty channel leaves it empty, and that both flags and the reported location never change once set. Some behaviour only the bench scenarios can show. These are the exact depth of each counter, the cancelling of a same-cycle send and return, the window of edges in which a stalled timer raises `deadlock`, a timer that was cleared never firing, and which channel is reported when two timers are racing.

// File: rtl/ccw_pkg.sv
// Shared types for the credit tracker and stall watchdog.
// Assumes nothing beyond a single clock domain.
package ccw_pkg;
    typedef enum logic {
        STALL_IDLE  = 1'b0,
        STALL_ARMED = 1'b1
    } stall_state_e;
endpackage

// File: rtl/ccw_interval_gen.sv
// Free-running divider that pulses tick for one cycle every INTERVAL cycles.
// Assumes INTERVAL >= 2.
module ccw_interval_gen #(
    parameter int unsigned INTERVAL = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned IW = $clog2(INTERVAL);

    logic [IW-1:0] phase_q;

    assign tick = (phase_q == IW'(INTERVAL - 1));

    // Count cycles and wrap at the interval boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= '0;
        else if (tick) phase_q <= '0;
        else           phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/ccw_credit_cell.sv
// One downstream-slot counter. A take is honoured only when a slot is free.
// A give at full depth is refused and reported as overflow.
// Assumes DEPTH >= 1.
module ccw_credit_cell #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic avail,
    output logic took,
    output logic overflow
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0] slots_q;
    logic          full;

    assign avail    = (slots_q != '0);
    assign full     = (slots_q == CW'(DEPTH));
    assign took     = take && avail;
    assign overflow = give && !took && full;

    // Track the free slots; a take and a give together cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= CW'(DEPTH);
        end else if (took && !give) begin
            slots_q <= slots_q - 1'b1;
        end else if (give && !took && !full) begin
            slots_q <= slots_q + 1'b1;
        end
    end
endmodule

// File: rtl/ccw_stall_timer.sv
// Stall timer for one channel. Arm loads zero and starts it. Clear sends it
// back to idle. Each tick advances an armed timer, which saturates one past
// LIMIT. Arm has priority over clear and over tick.
module ccw_stall_timer
    import ccw_pkg::*;
#(
    parameter int unsigned LIMIT = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int unsigned TW = $clog2(LIMIT + 2);

    stall_state_e  state_q;
    logic [TW-1:0] age_q;

    assign expired = (state_q == STALL_ARMED) && (age_q > TW'(LIMIT));

    // Arm, clear or age the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= STALL_IDLE;
            age_q   <= '0;
        end else if (arm) begin
            state_q <= STALL_ARMED;
            age_q   <= '0;
        end else if (clear) begin
            state_q <= STALL_IDLE;
            age_q   <= '0;
        end else if (tick && state_q == STALL_ARMED && age_q <= TW'(LIMIT)) begin
            age_q <= age_q + 1'b1;
        end
    end
endmodule

// File: rtl/ccw_lowest_pick.sv
// Priority finder: returns the lowest set index of req and whether any is set.
module ccw_lowest_pick #(
    parameter int unsigned N = 10
) (
    input  logic [N-1:0]         req,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int unsigned XW = $clog2(N);

    // Scan from the top so that the lowest request is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = XW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/credit_watchdog.sv
// Credit counters with a stall watchdog for every output port and virtual
// channel. Assumes that at most one send and one credit return arrive per
// cycle and that port values at or above NUM_PORTS are never driven.
module credit_watchdog #(
    parameter int unsigned NUM_PORTS      = 5,
    parameter int unsigned NUM_VCS        = 2,
    parameter int unsigned CREDITS        = 4,
    parameter int unsigned CHECK_INTERVAL = 50,
    parameter int unsigned STALL_LIMIT    = 50000,
    localparam int unsigned PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int unsigned VW = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1,
    localparam int unsigned NCH = NUM_PORTS * NUM_VCS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           send_valid,
    input  logic [PW-1:0]  send_port,
    input  logic [VW-1:0]  send_vc,
    input  logic           credit_valid,
    input  logic [PW-1:0]  credit_port,
    input  logic [VW-1:0]  credit_vc,
    output logic [NCH-1:0] credit_avail,
    output logic           deadlock,
    output logic [PW-1:0]  dl_port,
    output logic [VW-1:0]  dl_vc,
    output logic           overflow_err
);
    localparam int unsigned XW = $clog2(NCH);

    logic           tick;
    logic [NCH-1:0] took;
    logic [NCH-1:0] ovf;
    logic [NCH-1:0] expired;
    logic           any_expired;
    logic [XW-1:0]  first_idx;
    logic           deadlock_q;
    logic [PW-1:0]  dl_port_q;
    logic [VW-1:0]  dl_vc_q;
    logic           overflow_q;

    ccw_interval_gen #(.INTERVAL(CHECK_INTERVAL)) i_interval (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam int unsigned CH_PORT = g / NUM_VCS;
        localparam int unsigned CH_VC   = g % NUM_VCS;

        logic send_hit;
        logic credit_hit;

        assign send_hit   = send_valid && send_port == PW'(CH_PORT) && send_vc == VW'(CH_VC);
        assign credit_hit = credit_valid && credit_port == PW'(CH_PORT) && credit_vc == VW'(CH_VC);

        ccw_credit_cell #(.DEPTH(CREDITS)) i_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (send_hit),
            .give    (credit_hit),
            .avail   (credit_avail[g]),
            .took    (took[g]),
            .overflow(ovf[g])
        );

        ccw_stall_timer #(.LIMIT(STALL_LIMIT)) i_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm    (took[g]),
            .clear  (credit_hit),
            .tick   (tick),
            .expired(expired[g])
        );
    end

    ccw_lowest_pick #(.N(NCH)) i_pick (
        .req(expired),
        .any(any_expired),
        .idx(first_idx)
    );

    // Latch the first expiry and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deadlock_q <= 1'b0;
            dl_port_q  <= '0;
            dl_vc_q    <= '0;
        end else if (!deadlock_q && any_expired) begin
            deadlock_q <= 1'b1;
            dl_port_q  <= PW'(first_idx / XW'(NUM_VCS));
            dl_vc_q    <= VW'(first_idx % XW'(NUM_VCS));
        end
    end

    // Record any refused credit and keep the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n)    overflow_q <= 1'b0;
        else if (|ovf) overflow_q <= 1'b1;
    end

    assign deadlock     = deadlock_q;
    assign dl_port      = dl_port_q;
    assign dl_vc        = dl_vc_q;
    assign overflow_err = overflow_q;
endmodule

// File: rtl/ccw_checker.sv
// Property checker for credit_watchdog; it is bound to every instance.
module ccw_checker #(
    parameter int unsigned NUM_PORTS = 5,
    parameter int unsigned NUM_VCS   = 2,
    parameter int unsigned PW        = 3,
    parameter int unsigned VW        = 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         send_valid,
    input logic [PW-1:0]                send_port,
    input logic [VW-1:0]                send_vc,
    input logic                         credit_valid,
    input logic [PW-1:0]                credit_port,
    input logic [VW-1:0]                credit_vc,
    input logic [NUM_PORTS*NUM_VCS-1:0] credit_avail,
    input logic                         deadlock,
    input logic [PW-1:0]                dl_port,
    input logic [VW-1:0]                dl_vc,
    input logic                         overflow_err
);
    localparam int unsigned NCH = NUM_PORTS * NUM_VCS;

    logic [NCH-1:0] send_oh;
    logic [NCH-1:0] cred_oh;

    // One-hot channel selects decoded from the strobes.
    always_comb begin
        send_oh = '0;
        cred_oh = '0;
        for (int i = 0; i < NCH; i++) begin
            send_oh[i] = send_valid && (int'(send_port) * NUM_VCS + int'(send_vc) == i);
            cred_oh[i] = credit_valid && (int'(credit_port) * NUM_VCS + int'(credit_vc) == i);
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (&credit_avail && !deadlock && !overflow_err));

    for (genvar g = 0; g < NCH; g++) begin : g_prop
        p_credit_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cred_oh[g] && !send_oh[g]) |=> credit_avail[g]);
        p_dry_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (send_oh[g] && !cred_oh[g] && !credit_avail[g]) |=> !credit_avail[g]);
    end

    p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    p_deadlock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |=> (deadlock && $stable(dl_port) && $stable(dl_vc)));

    p_report_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |-> (int'(dl_port) < NUM_PORTS && int'(dl_vc) < NUM_VCS));
endmodule

bind credit_watchdog ccw_checker #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_VCS  (NUM_VCS),
    .PW       (PW),
    .VW       (VW)
) i_ccw_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .send_valid  (send_valid),
    .send_port   (send_port),
    .send_vc     (send_vc),
    .credit_valid(credit_valid),
    .credit_port (credit_port),
    .credit_vc   (credit_vc),
    .credit_avail(credit_avail),
    .deadlock    (deadlock),
    .dl_port     (dl_port),
    .dl_vc       (dl_vc),
    .overflow_err(overflow_err)
);

// File: tb/test_credit_watchdog.sv
module test_credit_watchdog;
    localparam int P   = 5;
    localparam int V   = 2;
    localparam int CR  = 4;
    localparam int IV  = 8;
    localparam int LIM = 6;
    localparam int NCH = P * V;

    typedef struct {
        logic [NCH-1:0] avail;
        logic           ovf;
        string          tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           send_valid = 1'b0;
    logic [2:0]     send_port = '0;
    logic [0:0]     send_vc = '0;
    logic           credit_valid = 1'b0;
    logic [2:0]     credit_port = '0;
    logic [0:0]     credit_vc = '0;
    logic [NCH-1:0] credit_avail;
    logic           deadlock;
    logic [2:0]     dl_port;
    logic [0:0]     dl_vc;
    logic           overflow_err;

    int   checks = 0;
    int   fails = 0;
    int   cred [NCH];
    logic ovf_m = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    credit_watchdog #(
        .NUM_PORTS(P), .NUM_VCS(V), .CREDITS(CR),
        .CHECK_INTERVAL(IV), .STALL_LIMIT(LIM)
    ) i_credit_watchdog (
        .clk(clk), .rst_n(rst_n),
        .send_valid(send_valid), .send_port(send_port), .send_vc(send_vc),
        .credit_valid(credit_valid), .credit_port(credit_port), .credit_vc(credit_vc),
        .credit_avail(credit_avail), .deadlock(deadlock),
        .dl_port(dl_port), .dl_vc(dl_vc), .overflow_err(overflow_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] model_avail();
        logic [NCH-1:0] a;
        for (int i = 0; i < NCH; i++) a[i] = (cred[i] > 0);
        return a;
    endfunction

    // Driver: apply one cycle of strobes, update the model, queue the expectation.
    task automatic do_op(input bit sv, input int sp, input int svc,
                         input bit cv, input int cp, input int cvc, input string tag);
        int si;
        int ci;
        bit took;
        exp_t e;
        @(negedge clk);
        send_valid = sv; send_port = 3'(sp); send_vc = 1'(svc);
        credit_valid = cv; credit_port = 3'(cp); credit_vc = 1'(cvc);
        si = sp * V + svc;
        ci = cp * V + cvc;
        took = sv && cred[si] > 0;
        if (took && !(cv && ci == si)) cred[si]--;
        if (cv && !(took && ci == si)) begin
            if (cred[ci] == CR) ovf_m = 1'b1;
            else cred[ci]++;
        end
        e.avail = model_avail();
        e.ovf = ovf_m;
        e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #2;
        send_valid = 1'b0;
        credit_valid = 1'b0;
    endtask

    // Monitor: compare queued expectations just after the capturing edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " credit_avail"}, 64'(credit_avail), 64'(e.avail));
            check({e.tag, " overflow_err"}, 64'(overflow_err), 64'(e.ovf));
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) cred[i] = CR;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: reset state
        check("R1 avail", 64'(credit_avail), {(64-NCH)'(0), {NCH{1'b1}}});
        check("R1 deadlock", 64'(deadlock), 64'(0));
        check("R1 overflow", 64'(overflow_err), 64'(0));

        // R2 and R3: drain channel (1,0)
        for (int k = 0; k < CR; k++) do_op(1, 1, 0, 0, 0, 0, "R2 R3 send drain");
        // R4: send on empty is ignored; one credit gives exactly one slot
        do_op(1, 1, 0, 0, 0, 0, "R4 dry send");
        do_op(0, 0, 0, 1, 1, 0, "R4 one credit");
        do_op(1, 1, 0, 0, 0, 0, "R4 back to empty");
        do_op(0, 0, 0, 1, 1, 0, "R2 credit up");
        // R5: same-cycle send and credit cancel
        do_op(1, 1, 0, 1, 1, 0, "R5 send+credit");
        do_op(1, 1, 0, 0, 0, 0, "R5 follow send");
        for (int k = 0; k < CR; k++) do_op(0, 0, 0, 1, 1, 0, "R2 refill");
        // R6: credit at full depth
        do_op(0, 0, 0, 1, 0, 1, "R6 overflow credit");
        for (int k = 0; k < CR; k++) do_op(1, 0, 1, 0, 0, 0, "R6 depth kept");
        for (int k = 0; k < CR; k++) do_op(0, 0, 0, 1, 0, 1, "R6 refill");

        // R7: cleared timer never fires
        do_op(1, 4, 1, 0, 0, 0, "R7 arm");
        repeat (10) @(posedge clk);
        do_op(0, 0, 0, 1, 4, 1, "R7 clear");
        repeat (80) @(posedge clk);
        #1;
        check("R7 no deadlock", 64'(deadlock), 64'(0));

        // R8 and R9: two stalls, the older and lower channel is reported
        do_op(1, 2, 0, 0, 0, 0, "R8 arm 2/0");
        repeat (LIM * IV) @(posedge clk);
        #1;
        check("R8 not early", 64'(deadlock), 64'(0));
        do_op(1, 3, 1, 0, 0, 0, "R8 arm 3/1");
        repeat (IV) @(posedge clk);
        #1;
        check("R8 raised", 64'(deadlock), 64'(1));
        check("R9 port", 64'(dl_port), 64'(2));
        check("R9 vc", 64'(dl_vc), 64'(0));

        // R10: report sticks after the stalled channels get credits
        do_op(0, 0, 0, 1, 2, 0, "R10 credit 2/0");
        do_op(0, 0, 0, 1, 3, 1, "R10 credit 3/1");
        repeat (80) @(posedge clk);
        #1;
        check("R10 deadlock held", 64'(deadlock), 64'(1));
        check("R10 port held", 64'(dl_port), 64'(2));
        check("R10 vc held", 64'(dl_vc), 64'(0));

        repeat (2) @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule